// File: doc/BRIEF.md
# Byte Shift and Rotate Unit

This block moves an 8-bit operand by one bit position in any of seven ways: a circular rotate left or right, a rotate left or right through the carry, a zero-filling shift left or right, and a sign-keeping shift right. Two further operations swap 4-bit digits between an accumulator byte and a memory byte, in either direction. The data path is purely combinational. A registered flag word holds the condition bits. The carry bit of that word is the carry-in for every operation, and the word is rewritten on each clock edge where `op_en` is high.

Each operation code has its own rule for updating the flags. The "short accumulator form" select applies only to the four rotates. It makes an operation touch just the carry and the two arithmetic-helper bits, so the caller keeps the zero, sign and parity state it already had. The digit operations never change the carry. Any undefined operation code passes the operand through and leaves every flag as it was.

Operation codes (`op_sel`): 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 zero-fill left, 5 sign-keeping right, 6 zero-fill right, 7 digit left, 8 digit right, 9 to 15 undefined. Flag word bit positions: sign 7, zero 6, half-carry 4, parity/overflow 2, subtract 1, carry 0. Bits 5 and 3 are held.

Top module: `srot_unit`

## Requirements
- R1: While `rst_n` is low, and on its release, `flags` is 8'h00.
- R2: Code 0 gives {opnd[6:0],opnd[7]} with `cout`=opnd[7]. Code 1 gives {opnd[0],opnd[7:1]} with `cout`=opnd[0].
- R3: Code 2 gives {opnd[6:0],C} with `cout`=opnd[7]. Code 3 gives {C,opnd[7:1]} with `cout`=opnd[0]. C is `flags[0]`.
- R4: Code 4 gives {opnd[6:0],0} with `cout`=opnd[7]. Code 6 gives {0,opnd[7:1]} with `cout`=opnd[0].
- R5: Code 5 gives {opnd[7],opnd[7:1]} with `cout`=opnd[0].
- R6: When `op_en` is high and a rotate (with `acc_form`=0), a shift or a digit code is applied, the next `flags` has bit7 = res[7], bit6 = (res==0), bit2 = 1 when `res` has an even number of ones, bit4 = bit1 = 0, bit0 = `cout`, and bits 5 and 3 held.
- R7: When `op_en` is high and `acc_form` is 1 on codes 0 to 3, only bits 4 and 1 (both cleared) and bit 0 (set to `cout`) change. Bits 7, 6, 5, 3 and 2 keep their values.
- R8: `acc_form` has no effect on codes 4 to 8. Their flags follow R6.
- R9: Code 7 takes A=`opnd` and M=`mem_in`. It outputs `mem_out`={M[3:0],A[3:0]} and `res`={A[7:4],M[7:4]}.
- R10: Code 8 outputs `mem_out`={A[3:0],M[7:4]} and `res`={A[7:4],M[3:0]}.
- R11: Codes 7 and 8 keep the carry (`cout`=`flags[0]`). Their sign, zero and parity flags are taken from the new accumulator `res`.
- R12: Codes 9 to 15 give `res`=`opnd`, `mem_out`=`mem_in` and `cout`=`flags[0]`, and leave `flags` unchanged even when `op_en` is high.
- R13: With `op_en` low, `flags` holds its value, while `res`, `mem_out` and `cout` still follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Commit this cycle's flags on the clock edge |
| op_sel | input | 4 | Operation code |
| acc_form | input | 1 | Short accumulator form for the rotates |
| opnd | input | 8 | Operand, or accumulator for the digit operations |
| mem_in | input | 8 | Memory byte for the digit operations |
| res | output | 8 | Shifted operand or new accumulator |
| mem_out | output | 8 | New memory byte (equal to `mem_in` except for digit operations) |
| cout | output | 1 | Carry that the operation produces |
| flags | output | 8 | Registered flag word |

## Verification
The carry-in cannot be driven directly, because it is the stored carry flag. So each vector is preceded by a zero-fill shift left of either 8'h80 or 8'h00, which loads the wanted carry through the block's own ports. That preload also leaves zero and parity set. The short-form vectors therefore use operands whose full-form flags would differ from those held values. This is the only way to tell "kept" apart from "recomputed".

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_RLC = 4'd0;
  localparam logic [OPW-1:0] OP_RRC = 4'd1;
  localparam logic [OPW-1:0] OP_RLT = 4'd2;
  localparam logic [OPW-1:0] OP_RRT = 4'd3;
  localparam logic [OPW-1:0] OP_SLL = 4'd4;
  localparam logic [OPW-1:0] OP_SRA = 4'd5;
  localparam logic [OPW-1:0] OP_SRL = 4'd6;
  localparam logic [OPW-1:0] OP_DGL = 4'd7;
  localparam logic [OPW-1:0] OP_DGR = 4'd8;

  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_H = 4;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;

  typedef enum logic [1:0] {
    FK_HOLD  = 2'd0,
    FK_SHORT = 2'd1,
    FK_FULL  = 2'd2
  } fkind_e;

  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic is_zero(input logic [DW-1:0] v);
    return (v == '0);
  endfunction
endpackage

// File: rtl/srot_shift.sv
module srot_shift
  import srot_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  din,
  input  logic           cin,
  output logic [DW-1:0]  dout,
  output logic           cy
);
  logic msb, lsb;
  assign msb = din[DW-1];
  assign lsb = din[0];

  always_comb begin
    dout = din;
    cy   = cin;
    unique case (op)
      OP_RLC: begin dout = {din[DW-2:0], msb};  cy = msb; end
      OP_RRC: begin dout = {lsb, din[DW-1:1]};  cy = lsb; end
      OP_RLT: begin dout = {din[DW-2:0], cin};  cy = msb; end
      OP_RRT: begin dout = {cin, din[DW-1:1]};  cy = lsb; end
      OP_SLL: begin dout = {din[DW-2:0], 1'b0}; cy = msb; end
      OP_SRA: begin dout = {msb, din[DW-1:1]};  cy = lsb; end
      OP_SRL: begin dout = {1'b0, din[DW-1:1]}; cy = lsb; end
      default: begin dout = din; cy = cin; end
    endcase
  end
endmodule

// File: rtl/srot_digit.sv
module srot_digit
  import srot_pkg::*;
(
  input  logic          go_left,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem,
  output logic [DW-1:0] acc_new,
  output logic [DW-1:0] mem_new
);
  logic [NW-1:0] a_hi, a_lo, m_hi, m_lo;
  assign a_hi = acc[DW-1:NW];
  assign a_lo = acc[NW-1:0];
  assign m_hi = mem[DW-1:NW];
  assign m_lo = mem[NW-1:0];

  always_comb begin
    if (go_left) begin
      mem_new = {m_lo, a_lo};
      acc_new = {a_hi, m_hi};
    end else begin
      mem_new = {a_lo, m_hi};
      acc_new = {a_hi, m_lo};
    end
  end
endmodule

// File: rtl/srot_flags.sv
module srot_flags
  import srot_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  fkind_e        kind,
  input  logic [DW-1:0] val,
  input  logic          cnew,
  output logic [DW-1:0] fq
);
  logic [DW-1:0] fnext;

  always_comb begin
    fnext = fq;
    unique case (kind)
      FK_FULL: begin
        fnext[FB_S] = val[DW-1];
        fnext[FB_Z] = is_zero(val);
        fnext[FB_H] = 1'b0;
        fnext[FB_P] = even_ones(val);
        fnext[FB_N] = 1'b0;
        fnext[FB_C] = cnew;
      end
      FK_SHORT: begin
        fnext[FB_H] = 1'b0;
        fnext[FB_N] = 1'b0;
        fnext[FB_C] = cnew;
      end
      default: fnext = fq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  fq <= '0;
    else if (en) fq <= fnext;
  end
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_en,
  input  logic [OPW-1:0] op_sel,
  input  logic           acc_form,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  mem_in,
  output logic [DW-1:0]  res,
  output logic [DW-1:0]  mem_out,
  output logic           cout,
  output logic [DW-1:0]  flags
);
  logic          carry_in;
  logic          is_rot, is_shift, is_digit, is_known;
  logic [DW-1:0] sh_val, dg_acc, dg_mem;
  logic          sh_cy;
  fkind_e        kind;

  assign carry_in = flags[FB_C];
  assign is_rot   = (op_sel <= OP_RRT);
  assign is_shift = (op_sel >= OP_SLL) && (op_sel <= OP_SRL);
  assign is_digit = (op_sel == OP_DGL) || (op_sel == OP_DGR);
  assign is_known = is_rot || is_shift || is_digit;

  srot_shift u_shift (
    .op   (op_sel),
    .din  (opnd),
    .cin  (carry_in),
    .dout (sh_val),
    .cy   (sh_cy)
  );

  srot_digit u_digit (
    .go_left (op_sel == OP_DGL),
    .acc     (opnd),
    .mem     (mem_in),
    .acc_new (dg_acc),
    .mem_new (dg_mem)
  );

  always_comb begin
    if (is_digit) begin
      res     = dg_acc;
      mem_out = dg_mem;
      cout    = carry_in;
    end else begin
      res     = sh_val;
      mem_out = mem_in;
      cout    = sh_cy;
    end
  end

  always_comb begin
    if (!is_known)             kind = FK_HOLD;
    else if (is_rot && acc_form) kind = FK_SHORT;
    else                       kind = FK_FULL;
  end

  srot_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (op_en),
    .kind  (kind),
    .val   (res),
    .cnew  (cout),
    .fq    (flags)
  );
endmodule

// File: rtl/srot_chk.sv
module srot_chk
  import srot_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           op_en,
  input logic [OPW-1:0] op_sel,
  input logic           acc_form,
  input logic [DW-1:0]  opnd,
  input logic [DW-1:0]  mem_in,
  input logic [DW-1:0]  res,
  input logic [DW-1:0]  mem_out,
  input logic           cout,
  input logic [DW-1:0]  flags
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> flags == '0); // R1
  AST_ROT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_RLC) |-> cout == opnd[DW-1]); // R2
  AST_RT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_RRT) |-> res[DW-1] == flags[FB_C]); // R3
  AST_SRL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SRL) |-> res[DW-1] == 1'b0); // R4
  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SRA) |-> res[DW-1] == opnd[DW-1]); // R5
  AST_FULL_HN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel <= OP_DGR && !(op_sel <= OP_RRT && acc_form))
      |=> (flags[FB_H] == 1'b0 && flags[FB_N] == 1'b0)); // R6
  AST_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel >= OP_SLL && op_sel <= OP_DGR)
      |=> flags[FB_Z] == ($past(res) == '0)); // R8
  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel <= OP_DGR) |=> flags[FB_C] == $past(cout)); // R6
  AST_SHORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && acc_form && op_sel <= OP_RRT)
      |=> $stable(flags & 8'hEC)); // R7
  AST_DIGIT_AHI: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_DGL || op_sel == OP_DGR)
      |-> res[DW-1:NW] == opnd[DW-1:NW]); // R9
  AST_DIGIT_CKEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_sel == OP_DGL || op_sel == OP_DGR))
      |=> $stable(flags[FB_C])); // R11
  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_DGR) |-> (res == opnd && mem_out == mem_in)); // R12
  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_DGR) |=> $stable(flags)); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags)); // R13
endmodule

bind srot_unit srot_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_en    (op_en),
  .op_sel   (op_sel),
  .acc_form (acc_form),
  .opnd     (opnd),
  .mem_in   (mem_in),
  .res      (res),
  .mem_out  (mem_out),
  .cout     (cout),
  .flags    (flags)
);

// File: tb/sim_srot_unit.sv
module sim_srot_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_en;
  logic [3:0] op_sel;
  logic       acc_form;
  logic [7:0] opnd, mem_in;
  logic [7:0] res, mem_out, flags;
  logic       cout;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_f;

  always #10 clk = ~clk;

  srot_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .acc_form(acc_form), .opnd(opnd), .mem_in(mem_in),
    .res(res), .mem_out(mem_out), .cout(cout), .flags(flags)
  );

  // {op[38:35], acc[34], cin[33], opnd[32:25], mem[24:17], res[16:9], mem_out[8:1], cout[0]}
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 8'h81, 8'hA5, 8'h03, 8'hA5, 1'b1},
    {4'd0, 1'b0, 1'b1, 8'h40, 8'hA5, 8'h80, 8'hA5, 1'b0},
    {4'd1, 1'b0, 1'b0, 8'h01, 8'hA5, 8'h80, 8'hA5, 1'b1},
    {4'd1, 1'b0, 1'b1, 8'h82, 8'hA5, 8'h41, 8'hA5, 1'b0},
    {4'd2, 1'b0, 1'b1, 8'h80, 8'hA5, 8'h01, 8'hA5, 1'b1},
    {4'd2, 1'b0, 1'b0, 8'h55, 8'hA5, 8'hAA, 8'hA5, 1'b0},
    {4'd3, 1'b0, 1'b1, 8'h01, 8'hA5, 8'h80, 8'hA5, 1'b1},
    {4'd3, 1'b0, 1'b0, 8'hAB, 8'hA5, 8'h55, 8'hA5, 1'b1},
    {4'd4, 1'b0, 1'b1, 8'hC3, 8'hA5, 8'h86, 8'hA5, 1'b1},
    {4'd5, 1'b0, 1'b0, 8'h81, 8'hA5, 8'hC0, 8'hA5, 1'b1},
    {4'd5, 1'b0, 1'b1, 8'h7E, 8'hA5, 8'h3F, 8'hA5, 1'b0},
    {4'd6, 1'b0, 1'b1, 8'h81, 8'hA5, 8'h40, 8'hA5, 1'b1},
    {4'd7, 1'b1, 1'b1, 8'h12, 8'h34, 8'h13, 8'h42, 1'b1},
    {4'd8, 1'b0, 1'b0, 8'h12, 8'h34, 8'h14, 8'h23, 1'b0},
    {4'd9, 1'b0, 1'b1, 8'h5A, 8'h77, 8'h5A, 8'h77, 1'b1},
    {4'd0, 1'b1, 1'b0, 8'h81, 8'hA5, 8'h03, 8'hA5, 1'b1},
    {4'd3, 1'b1, 1'b1, 8'hFE, 8'hA5, 8'hFF, 8'hA5, 1'b0},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'hA5, 8'h00, 8'hA5, 1'b0},
    {4'd6, 1'b0, 1'b1, 8'h01, 8'hA5, 8'h00, 8'hA5, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd1)      return "R2";
    else if (op <= 4'd3) return "R3";
    else if (op == 4'd5) return "R5";
    else if (op <= 4'd6) return "R4";
    else if (op == 4'd7) return "R9";
    else if (op == 4'd8) return "R10";
    else                 return "R12";
  endfunction

  function automatic string ftag_of(input logic [3:0] op, input logic acc);
    if (op > 4'd8)                return "R12";
    else if (op >= 4'd7)          return "R11";
    else if (op <= 4'd3 && acc)   return "R7";
    else if (acc)                 return "R8";
    else                          return "R6";
  endfunction

  // Expected flag word, restated from the requirements
  function automatic logic [7:0] model_f(input logic [7:0] p, input logic [3:0] op,
                                         input logic acc, input logic [7:0] r,
                                         input logic c);
    logic [7:0] f;
    f = p;
    if (op > 4'd8) return p;
    f[0] = c; f[1] = 1'b0; f[4] = 1'b0;
    if (!(op <= 4'd3 && acc)) begin
      f[7] = r[7];
      f[6] = (r == 8'h00);
      f[2] = ($countones(r) % 2 == 0);
    end
    return f;
  endfunction

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Loads the carry through a zero-fill left shift of {c,7'b0}
  task automatic set_carry(input logic c);
    @(negedge clk);
    op_en = 1'b1; op_sel = 4'd4; acc_form = 1'b0;
    opnd = {c, 7'b0}; mem_in = 8'h00;
    @(negedge clk);
    exp_f = model_f(exp_f, 4'd4, 1'b0, 8'h00, c);
    op_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_en = 1'b0; op_sel = 4'd0; acc_form = 1'b0;
    opnd = 8'h00; mem_in = 8'h00; exp_f = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check8("R1", "flags in reset", flags, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1", "flags after reset", flags, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [7:0] er;
      logic ec;
      op = VEC[i][38:35];
      er = VEC[i][16:9];
      ec = VEC[i][0];
      set_carry(VEC[i][33]);
      op_en = 1'b1; op_sel = op; acc_form = VEC[i][34];
      opnd = VEC[i][32:25]; mem_in = VEC[i][24:17];
      #5;
      check8(tag_of(op), "res", res, er);
      check8(tag_of(op), "mem_out", mem_out, VEC[i][8:1]);
      check8(tag_of(op), "cout", {7'b0, cout}, {7'b0, ec});
      @(negedge clk);
      exp_f = model_f(exp_f, op, VEC[i][34], er, ec);
      check8(ftag_of(op, VEC[i][34]), "flags", flags, exp_f);
      op_en = 1'b0;
    end

    // R13: idle cycle, outputs follow inputs, flags held
    set_carry(1'b0);
    op_en = 1'b0; op_sel = 4'd4; acc_form = 1'b0; opnd = 8'h80; mem_in = 8'h3C;
    #5;
    check8("R13", "res idle", res, 8'h00);
    check8("R13", "cout idle", {7'b0, cout}, 8'h01);
    check8("R13", "mem_out idle", mem_out, 8'h3C);
    @(negedge clk);
    check8("R13", "flags idle", flags, exp_f);

    // R12: highest undefined code with commit enabled
    op_en = 1'b1; op_sel = 4'd15; acc_form = 1'b1; opnd = 8'h3C; mem_in = 8'h11;
    #5;
    check8("R12", "res undef", res, 8'h3C);
    check8("R12", "mem_out undef", mem_out, 8'h11);
    check8("R12", "cout undef", {7'b0, cout}, {7'b0, exp_f[0]});
    @(negedge clk);
    check8("R12", "flags undef", flags, exp_f);
    op_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule